// File: doc/BRIEF.md
# I2C Master Command and Receive Buffer Front End

This block sits between a processor-facing register port and the bit-level engine of an I2C master. Software queues work by writing a single data/command register: each write becomes one entry in a transmit command queue, either a byte to send or a request to read one byte from the bus. The bit engine drains that queue through a valid/take handshake, and every byte it receives is delivered through a one-cycle strobe into a receive queue. Software reads the same data/command register to collect received bytes.

Both queue occupancies can be read back. Two programmable thresholds drive level-sensitive service requests: one asks for more transmit work, the other reports that received data is waiting. A read-only parameter word reports both queue sizes, so driver code can size its bursts without build-time knowledge. An abort input, raised by the bit engine when a transfer is abandoned, empties both queues in one cycle. Three sticky error flags record misuse: pushing into a full queue, reading an empty one, and receive data lost to a full queue.

Register select codes on `reg_sel`: 0 data/command, 1 control, 2 transmit threshold, 3 receive threshold, 4 transmit level, 5 receive level, 6 parameter word, 7 error flags. Writes and reads take effect at the rising clock edge on which `reg_wr` or `reg_rd` is high; `reg_rdata` is combinational from `reg_sel` and the current state.

Top module: `i2cm_cmd_front`

## Requirements
- R1: A write to select 0 with `reg_wdata[8]`=0 queues the entry {0, `reg_wdata[7:0]`}; the engine sees entries on `eng_cmd_data` in write order while `eng_cmd_valid` is high, and each cycle with `eng_cmd_take` high removes one.
- R2: A write to select 0 with `reg_wdata[8]`=1 queues a read request, presented as `eng_cmd_data`=9'h100 (bit 8 set, bits 7:0 zero) regardless of the written low byte.
- R3: A read of select 0 returns the oldest received byte in bits 7:0 (upper bits zero) and removes it from the receive queue.
- R4: Selects 4 and 5 read the current number of entries in the transmit and receive queues; both are 0 after reset.
- R5: Select 6 reads transmit depth minus one in bits 23:16 and receive depth minus one in bits 15:8, all other bits zero.
- R6: `irq_rx_full` is high exactly when the receive level is greater than the receive threshold (select 3, reset value 0), so with threshold 0 one byte raises it.
- R7: `irq_tx_empty` is high exactly when the transmit level is less than or equal to the transmit threshold (select 2, reset value 0).
- R8: A cycle with `abort` high empties both queues: in the next cycle both levels read 0; any push in that same cycle is discarded.
- R9: A write to select 0 while the transmit queue holds its depth of entries is dropped and sets error flag bit 0.
- R10: A read of select 0 while the receive queue is empty returns zero and sets error flag bit 1.
- R11: An `eng_rx_valid` strobe while the receive queue is full drops the byte and sets error flag bit 2.
- R12: Bit 0 of select 1 is the controller enable (reset 0); writes to selects 2 and 3 while it is 1 leave the thresholds unchanged.
- R13: Reading select 7 returns the error flags in bits 2:0 and clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on select 0 and 7) |
| reg_sel | input | 3 | Register select code |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| eng_cmd_valid | output | 1 | Transmit queue holds an entry |
| eng_cmd_data | output | 9 | Oldest transmit entry; bit 8 marks a read request |
| eng_cmd_take | input | 1 | Engine consumes the presented entry |
| eng_rx_valid | input | 1 | Engine delivers one received byte |
| eng_rx_byte | input | 8 | Received byte |
| abort | input | 1 | Transfer abandoned; flush both queues |
| irq_tx_empty | output | 1 | Transmit level at or below threshold |
| irq_rx_full | output | 1 | Receive level above threshold |

## Verification
The hardest states to reach are the two queue boundaries under pressure: a host write arriving when the transmit queue is exactly full and a received byte arriving when the receive queue is exactly full. The stimulus withholds `eng_cmd_take` while pushing one entry more than the depth, and strobes one byte more than the depth into the receive side before reading any, then drains each queue to prove the extra entry never landed and that order survived. The abort case is reached by loading both queues partially before pulsing the flush, and the threshold lock by setting the enable bit between two threshold writes.

// File: rtl/i2cm_front_pkg.sv
package i2cm_front_pkg;

  typedef enum logic [2:0] {
    SEL_DATA  = 3'd0,
    SEL_CTRL  = 3'd1,
    SEL_TXTHR = 3'd2,
    SEL_RXTHR = 3'd3,
    SEL_TXLVL = 3'd4,
    SEL_RXLVL = 3'd5,
    SEL_PARAM = 3'd6,
    SEL_FLAGS = 3'd7
  } reg_sel_e;

  localparam int FLAG_TX_OVER  = 0;
  localparam int FLAG_RX_UNDER = 1;
  localparam int FLAG_RX_OVER  = 2;

  // transmit side wants service while occupancy has not risen above the mark
  function automatic logic needs_refill(input logic [7:0] lvl, input logic [7:0] mark);
    return lvl <= mark;
  endfunction

  // receive side wants service once occupancy passes the mark
  function automatic logic has_backlog(input logic [7:0] lvl, input logic [7:0] mark);
    return lvl > mark;
  endfunction

  function automatic logic [31:0] depth_word(input int tx_depth, input int rx_depth);
    return {8'h00, 8'(tx_depth - 1), 8'(rx_depth - 1), 8'h00};
  endfunction

  function automatic logic [8:0] encode_cmd(input logic [31:0] wdata);
    return wdata[8] ? 9'h100 : {1'b0, wdata[7:0]};
  endfunction

endpackage

// File: rtl/i2cm_front_fifo.sv
module i2cm_front_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [7:0]       level,
  output logic             full,
  output logic             empty,
  output logic             push_drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [LW-1:0]    count;
  logic             push_ok, pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count == LW'(DEPTH));
  assign empty     = (count == '0);
  assign push_ok   = push && !full && !flush;
  assign pop_ok    = pop && !empty && !flush;
  assign push_drop = push && full && !flush;
  assign dout      = mem[rd_ptr];
  assign level     = 8'(count);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_level_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    level <= 8'(DEPTH));
  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == 8'd0));
  p_full_push_drop_r9_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (push_drop && !pop) |=> $stable(level));
endmodule

// File: rtl/i2cm_front_levels.sv
module i2cm_front_levels
  import i2cm_front_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] tx_level,
  input  logic [7:0] rx_level,
  input  logic [7:0] tx_mark,
  input  logic [7:0] rx_mark,
  output logic       tx_req,
  output logic       rx_req
);
  assign tx_req = needs_refill(tx_level, tx_mark);
  assign rx_req = has_backlog(rx_level, rx_mark);

  p_rx_one_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mark == 8'd0 && rx_level != 8'd0) |-> rx_req);
  p_tx_idle_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == 8'd0) |-> tx_req);
endmodule

// File: rtl/i2cm_cmd_front.sv
module i2cm_cmd_front
  import i2cm_front_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        eng_cmd_valid,
  output logic [8:0]  eng_cmd_data,
  input  logic        eng_cmd_take,
  input  logic        eng_rx_valid,
  input  logic [7:0]  eng_rx_byte,
  input  logic        abort,
  output logic        irq_tx_empty,
  output logic        irq_rx_full
);
  reg_sel_e   sel;
  logic       wr_data, rd_data, rd_flags;
  logic       ctl_en;
  logic [7:0] tx_mark, rx_mark;
  logic [2:0] err_flags;

  logic [7:0] tx_lvl, rx_lvl, rx_head;
  logic       tx_full, tx_empty, rx_full, rx_empty;
  logic       ev_tx_over, ev_rx_over, ev_rx_under;

  assign sel      = reg_sel_e'(reg_sel);
  assign wr_data  = reg_wr && (sel == SEL_DATA);
  assign rd_data  = reg_rd && (sel == SEL_DATA);
  assign rd_flags = reg_rd && (sel == SEL_FLAGS);

  i2cm_front_fifo #(.WIDTH(9), .DEPTH(TX_DEPTH)) u_txq (
    .clk, .rst_n, .flush(abort),
    .push(wr_data), .din(encode_cmd(reg_wdata)),
    .pop(eng_cmd_take), .dout(eng_cmd_data),
    .level(tx_lvl), .full(tx_full), .empty(tx_empty),
    .push_drop(ev_tx_over)
  );

  i2cm_front_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) u_rxq (
    .clk, .rst_n, .flush(abort),
    .push(eng_rx_valid), .din(eng_rx_byte),
    .pop(rd_data), .dout(rx_head),
    .level(rx_lvl), .full(rx_full), .empty(rx_empty),
    .push_drop(ev_rx_over)
  );

  i2cm_front_levels u_lvl (
    .clk, .rst_n,
    .tx_level(tx_lvl), .rx_level(rx_lvl),
    .tx_mark, .rx_mark,
    .tx_req(irq_tx_empty), .rx_req(irq_rx_full)
  );

  assign eng_cmd_valid = !tx_empty;
  assign ev_rx_under   = rd_data && rx_empty && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en  <= 1'b0;
      tx_mark <= 8'd0;
      rx_mark <= 8'd0;
    end else if (reg_wr) begin
      if (sel == SEL_CTRL)             ctl_en  <= reg_wdata[0];
      if (sel == SEL_TXTHR && !ctl_en) tx_mark <= reg_wdata[7:0];
      if (sel == SEL_RXTHR && !ctl_en) rx_mark <= reg_wdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_flags <= '0;
    else begin
      err_flags <= (rd_flags ? 3'b000 : err_flags)
                 | {ev_rx_over, ev_rx_under, ev_tx_over};
    end
  end

  always_comb begin
    unique case (sel)
      SEL_DATA:  reg_rdata = {24'h0, rx_empty ? 8'h00 : rx_head};
      SEL_CTRL:  reg_rdata = {31'h0, ctl_en};
      SEL_TXTHR: reg_rdata = {24'h0, tx_mark};
      SEL_RXTHR: reg_rdata = {24'h0, rx_mark};
      SEL_TXLVL: reg_rdata = {24'h0, tx_lvl};
      SEL_RXLVL: reg_rdata = {24'h0, rx_lvl};
      SEL_PARAM: reg_rdata = depth_word(TX_DEPTH, RX_DEPTH);
      SEL_FLAGS: reg_rdata = {29'h0, err_flags};
      default:   reg_rdata = 32'h0;
    endcase
  end

  p_thr_lock_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && reg_wr && (sel == SEL_TXTHR || sel == SEL_RXTHR))
      |=> ($stable(tx_mark) && $stable(rx_mark)));
  p_under_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && rx_empty) |-> (reg_rdata == 32'h0));
  p_tx_over_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_over |=> err_flags[FLAG_TX_OVER]);
  p_rx_over_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_over |=> err_flags[FLAG_RX_OVER]);
  p_read_cmd_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_cmd_valid && eng_cmd_data[8]) |-> (eng_cmd_data[7:0] == 8'h00));
endmodule

// File: tb/i2cm_cmd_front_test.sv
`timescale 1ns/1ps
module i2cm_cmd_front_test;
  localparam int TXD = 8;
  localparam int RXD = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        eng_cmd_valid;
  logic [8:0]  eng_cmd_data;
  logic        eng_cmd_take = 1'b0;
  logic        eng_rx_valid = 1'b0;
  logic [7:0]  eng_rx_byte = 8'h0;
  logic        abort = 1'b0;
  logic        irq_tx_empty, irq_rx_full;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  i2cm_cmd_front #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) uut (
    .clk, .rst_n, .reg_wr, .reg_rd, .reg_sel, .reg_wdata, .reg_rdata,
    .eng_cmd_valid, .eng_cmd_data, .eng_cmd_take,
    .eng_rx_valid, .eng_rx_byte, .abort, .irq_tx_empty, .irq_rx_full
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  // read with side effects: data sampled before the edge that applies them
  task automatic rd(input logic [2:0] s, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_sel = s;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] s, output logic [31:0] d);
    @(negedge clk); reg_sel = s; #1 d = reg_rdata;
  endtask

  task automatic rx_in(input logic [7:0] b);
    @(negedge clk); eng_rx_valid = 1'b1; eng_rx_byte = b;
    @(negedge clk); eng_rx_valid = 1'b0;
  endtask

  task automatic take(input string req, input logic [8:0] exp);
    @(negedge clk);
    check(req, {31'h0, eng_cmd_valid}, 32'h1);
    check(req, {23'h0, eng_cmd_data}, {23'h0, exp});
    eng_cmd_take = 1'b1;
    @(negedge clk); eng_cmd_take = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    peek(3'd4, v); check("R4 tx level after reset", v, 0);
    peek(3'd5, v); check("R4 rx level after reset", v, 0);
    peek(3'd6, v); check("R5 parameter word", v, {8'h0, 8'(TXD-1), 8'(RXD-1), 8'h0});
    check("R7 tx request at reset", {31'h0, irq_tx_empty}, 1);
    check("R6 rx request at reset", {31'h0, irq_rx_full}, 0);
    check("R1 no command at reset", {31'h0, eng_cmd_valid}, 0);
  endtask

  task automatic t_commands();
    logic [31:0] v;
    wr(3'd0, 32'h0000_00A5);
    wr(3'd0, 32'h0000_01FF);
    wr(3'd0, 32'hFFFF_FE3C);
    peek(3'd4, v); check("R4 tx level three", v, 3);
    take("R1 first byte", 9'h0A5);
    take("R2 read request", 9'h100);
    take("R1 third byte", 9'h03C);
    check("R1 queue drained", {31'h0, eng_cmd_valid}, 0);
  endtask

  task automatic t_receive();
    logic [31:0] v;
    rx_in(8'h11); rx_in(8'h22);
    peek(3'd5, v); check("R4 rx level two", v, 2);
    check("R6 one-or-more with mark 0", {31'h0, irq_rx_full}, 1);
    rd(3'd0, v); check("R3 oldest byte", v, 32'h11);
    rd(3'd0, v); check("R3 second byte", v, 32'h22);
    check("R6 clears when empty", {31'h0, irq_rx_full}, 0);
  endtask

  task automatic t_rx_mark();
    logic [31:0] v;
    wr(3'd3, 32'd2);
    rx_in(8'h31); rx_in(8'h32);
    check("R6 level equal to mark", {31'h0, irq_rx_full}, 0);
    rx_in(8'h33);
    check("R6 level above mark", {31'h0, irq_rx_full}, 1);
    for (int i = 0; i < 3; i++) begin
      rd(3'd0, v); check("R3 ordered drain", v, 32'h31 + i);
    end
    wr(3'd3, 32'd0);
  endtask

  task automatic t_tx_mark();
    wr(3'd2, 32'd3);
    for (int i = 0; i < 3; i++) wr(3'd0, 32'h40 + i);
    check("R7 level equal to mark", {31'h0, irq_tx_empty}, 1);
    wr(3'd0, 32'h43);
    check("R7 level above mark", {31'h0, irq_tx_empty}, 0);
    for (int i = 0; i < 4; i++) take("R1 drain", 9'(8'h40 + i));
    wr(3'd2, 32'd0);
  endtask

  task automatic t_tx_over();
    logic [31:0] v;
    for (int i = 0; i < TXD; i++) wr(3'd0, 32'h50 + i);
    wr(3'd0, 32'h77);
    peek(3'd4, v); check("R9 level stays at depth", v, TXD);
    rd(3'd7, v); check("R9 overflow flag", v, 32'h1);
    rd(3'd7, v); check("R13 flags cleared by read", v, 32'h0);
    for (int i = 0; i < TXD; i++) take("R9 original entries kept", 9'(8'h50 + i));
    check("R9 dropped entry absent", {31'h0, eng_cmd_valid}, 0);
  endtask

  task automatic t_rx_under();
    logic [31:0] v;
    rd(3'd0, v); check("R10 empty read is zero", v, 32'h0);
    rd(3'd7, v); check("R10 underflow flag", v, 32'h2);
  endtask

  task automatic t_rx_over();
    logic [31:0] v;
    for (int i = 1; i <= RXD + 1; i++) rx_in(8'(i));
    peek(3'd5, v); check("R11 level stays at depth", v, RXD);
    rd(3'd7, v); check("R11 overflow flag", v, 32'h4);
    for (int i = 1; i <= RXD; i++) begin
      rd(3'd0, v); check("R11 stored bytes in order", v, i);
    end
    peek(3'd5, v); check("R11 extra byte absent", v, 0);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    wr(3'd2, 32'd4);
    wr(3'd1, 32'd1);
    wr(3'd2, 32'd6);
    wr(3'd3, 32'd5);
    peek(3'd2, v); check("R12 tx mark locked", v, 4);
    peek(3'd3, v); check("R12 rx mark locked", v, 0);
    wr(3'd1, 32'd0);
    wr(3'd2, 32'd6);
    peek(3'd2, v); check("R12 tx mark writable when disabled", v, 6);
    wr(3'd2, 32'd0);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    wr(3'd0, 32'h61); wr(3'd0, 32'h62);
    rx_in(8'h71); rx_in(8'h72);
    @(negedge clk); abort = 1'b1; eng_rx_valid = 1'b1; eng_rx_byte = 8'h99;
    @(negedge clk); abort = 1'b0; eng_rx_valid = 1'b0;
    peek(3'd4, v); check("R8 tx flushed", v, 0);
    peek(3'd5, v); check("R8 rx flushed, push same cycle dropped", v, 0);
    check("R8 tx request after flush", {31'h0, irq_tx_empty}, 1);
    check("R8 rx request after flush", {31'h0, irq_rx_full}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_commands();
    t_receive();
    t_rx_mark();
    t_tx_mark();
    t_tx_over();
    t_rx_under();
    t_rx_over();
    t_lock();
    t_abort();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule